// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block looks after the single even-parity bit that covers a 32-bit multiplexed address/data bus and its 4-bit command/byte-enable field. Whenever the local agent drives the address/data lines, the block produces the matching parity bit one clock later and enables it onto the bus. It keeps that bit held while the agent waits, so parity stays valid until one clock after the data phase completes. The parity output-enable follows the address/data output-enable, delayed by the same clock.

When another agent drives the bus, the block works as a checker. On an address phase, or on a completed data phase in which the local agent did not drive the lines, it registers the parity of the bus value. One clock later it compares that against the received parity bit. A mismatch on an address phase raises a one-clock system-error pulse. A mismatch on a data phase raises a one-clock data-parity-error pulse. Each of these reports has its own enable.

The direction and role of a phase come from the address/data output-enable. The master enables it for address phases and for write data. The target enables it for read data. The block therefore drives parity exactly when its agent owns the lines, and checks it otherwise.

Top module: `bus_parity_unit`

## Requirements
- R1: While `ad_oe_i` is high at a clock, `par_o` after that clock equals the XOR of all 36 bits of `ad_i` and `cbe_i` sampled at that clock. The 37 bits `ad_i`, `cbe_i` and parity together then hold an even number of ones.
- R2: `par_oe_o` equals the value `ad_oe_i` had at the previous clock.
- R3: While `ad_oe_i` is low at a clock, `par_o` keeps its value across that clock. It holds the parity of the last driven bus value, or 0 if nothing has been driven since reset.
- R4: A clock with `addr_phase_i` high and `ad_oe_i` low opens an address check. At the next clock, if `par_i` differs from the XOR of the 36 bus bits captured at the opening clock and `serr_en_i` is high, `serr_o` is high for the one clock period that follows.
- R5: A clock with `irdy_i` and `trdy_i` both high, `addr_phase_i` low and `ad_oe_i` low opens a data check. It is evaluated in the same way as R4, but it drives `perr_o` and is gated by `perr_en_i`.
- R6: The enables are sampled at the clock where `par_i` is compared. A low enable suppresses its error output for that comparison.
- R7: A clock where `ad_oe_i` is high, or where there is neither an address phase nor a completed data phase, opens no check. The clock after the following one shows `perr_o` and `serr_o` low whatever `par_i` is.
- R8: After a clock with `rst_n` low, `par_o`, `par_oe_o`, `perr_o` and `serr_o` are all 0.
- R9: The error outputs are not sticky. Each mismatch yields exactly one clock of error, and a later matching comparison leaves the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_i | input | 32 | Address/data bus value |
| cbe_i | input | 4 | Command/byte-enable value |
| par_i | input | 1 | Parity bit received from the bus |
| ad_oe_i | input | 1 | Local agent drives ad/cbe this clock |
| addr_phase_i | input | 1 | This clock is an address phase |
| irdy_i | input | 1 | Initiator ready |
| trdy_i | input | 1 | Target ready |
| perr_en_i | input | 1 | Enables data parity error reporting |
| serr_en_i | input | 1 | Enables address parity error reporting |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Parity output-enable |
| perr_o | output | 1 | Data parity error pulse |
| serr_o | output | 1 | Address parity error pulse |

## Verification
The assertions check several properties on every clock:
- the one-clock lag of the parity enable;
- the even-parity relation of a driven bit;
- holding while not driving;
- that errors never follow a cycle in which the block drove the bus;
- that the two error outputs never fire together.

Only the bench scenarios can show the following:
- that each of the 36 bit positions really reaches the checker;
- that an address check reports on the system-error output and a data check on the data error output;
- that the enables are sampled at the comparison clock;
- that a matching comparison after a mismatch clears the report.

// File: rtl/bpar_pkg.sv
// Shared types for the bus parity unit.
// Assumes: one check at most is pending per clock.
package bpar_pkg;
    typedef enum logic [1:0] {
        CHK_NONE = 2'd0,
        CHK_ADDR = 2'd1,
        CHK_DATA = 2'd2
    } chk_kind_t;
endpackage

// File: rtl/bpar_tree.sv
// Lane-split XOR reduction of the address/data bus and command/byte-enable.
// Lane i covers one slice of the data bus plus command bit i.
// Assumes: AD_W is a multiple of BE_W. Purely combinational.
module bpar_tree #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_i,
    output logic            par_o
);
    localparam int LANE_W = AD_W / BE_W;

    logic [BE_W-1:0] lane_par;

    // per-lane parity of data slice and its command bit
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_par[g] = (^ad_i[g*LANE_W +: LANE_W]) ^ cbe_i[g];
    end

    // fold lanes into the even-parity bit
    always_comb begin
        par_o = ^lane_par;
    end
endmodule

// File: rtl/bpar_drive.sv
// Parity launch path: registers the computed parity one clock behind the bus
// and holds it while the local agent is not driving; the enable trails ad_oe.
// Assumes: bus_par_i is the parity of the bus value at the same clock.
module bpar_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic ad_oe_i,
    input  logic bus_par_i,
    output logic par_o,
    output logic par_oe_o
);
    // launch or hold parity, delay the output-enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_o    <= 1'b0;
            par_oe_o <= 1'b0;
        end else begin
            par_oe_o <= ad_oe_i;
            if (ad_oe_i) par_o <= bus_par_i;
        end
    end

    // R2
    oe_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_i |=> par_oe_o);
    // R2
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe_i |=> !par_oe_o);
    // R3
    par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe_i |=> $stable(par_o));
endmodule

// File: rtl/bpar_check.sv
// Receive-side checker: captures the kind of check and the computed bus
// parity, compares against the received bit one clock later, and emits a
// one-clock error pulse on the matching output when its enable is set.
// Assumes: enables are sampled at the comparison clock.
module bpar_check
    import bpar_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chk_kind_t kind_i,
    input  logic      bus_par_i,
    input  logic      par_i,
    input  logic      perr_en_i,
    input  logic      serr_en_i,
    output logic      perr_o,
    output logic      serr_o
);
    chk_kind_t pend_kind_q;
    logic      pend_par_q;
    logic      mismatch;

    // capture what must be checked on the next clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_kind_q <= CHK_NONE;
            pend_par_q  <= 1'b0;
        end else begin
            pend_kind_q <= kind_i;
            pend_par_q  <= bus_par_i;
        end
    end

    // received bit versus locally computed parity
    always_comb begin
        mismatch = par_i ^ pend_par_q;
    end

    // register one-clock error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_o <= 1'b0;
            serr_o <= 1'b0;
        end else begin
            perr_o <= mismatch && perr_en_i && (pend_kind_q == CHK_DATA);
            serr_o <= mismatch && serr_en_i && (pend_kind_q == CHK_ADDR);
        end
    end

    // R6
    perr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> $past(perr_en_i));
    // R6
    serr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> $past(serr_en_i));
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_kind_q == CHK_NONE) |=> (!perr_o && !serr_o));
endmodule

// File: rtl/bus_parity_unit.sv
// Top of the bus parity unit. Classifies each clock as an address check,
// a data check or nothing, computes bus parity once, and feeds both the
// launch path and the receive checker.
// Assumes: ad_oe_i is high exactly when the local agent drives ad/cbe,
// i.e. master on address and write data, target on read data.
module bus_parity_unit
    import bpar_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_i,
    input  logic            par_i,
    input  logic            ad_oe_i,
    input  logic            addr_phase_i,
    input  logic            irdy_i,
    input  logic            trdy_i,
    input  logic            perr_en_i,
    input  logic            serr_en_i,
    output logic            par_o,
    output logic            par_oe_o,
    output logic            perr_o,
    output logic            serr_o
);
    logic      bus_par;
    chk_kind_t kind;

    bpar_tree #(.AD_W(AD_W), .BE_W(BE_W)) u_tree (
        .ad_i  (ad_i),
        .cbe_i (cbe_i),
        .par_o (bus_par)
    );

    // decide whether this clock opens a check and of which kind
    always_comb begin
        kind = CHK_NONE;
        if (!ad_oe_i) begin
            if (addr_phase_i)           kind = CHK_ADDR;
            else if (irdy_i && trdy_i)  kind = CHK_DATA;
        end
    end

    bpar_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .ad_oe_i   (ad_oe_i),
        .bus_par_i (bus_par),
        .par_o     (par_o),
        .par_oe_o  (par_oe_o)
    );

    bpar_check u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind_i    (kind),
        .bus_par_i (bus_par),
        .par_i     (par_i),
        .perr_en_i (perr_en_i),
        .serr_en_i (serr_en_i),
        .perr_o    (perr_o),
        .serr_o    (serr_o)
    );

    // R1
    even_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_i |=> (^{ad_i, cbe_i, par_o}) == ^{$past(ad_i) ^ ad_i, $past(cbe_i) ^ cbe_i});
    // R7
    drive_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_i |=> ##1 (!perr_o && !serr_o));
    // R4
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(perr_o && serr_o));
endmodule

// File: tb/sim_bus_parity_unit.sv
module sim_bus_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ad_i;
    logic [3:0]  cbe_i;
    logic        par_i, ad_oe_i, addr_phase_i, irdy_i, trdy_i, perr_en_i, serr_en_i;
    logic        par_o, par_oe_o, perr_o, serr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    bit m_par, m_oe, m_perr, m_serr;
    bit pend_addr, pend_data, pend_par;
    logic [31:0] rs = 32'h1234_5678;

    always #4 clk = ~clk;

    bus_parity_unit u0 (.*);

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [31:0] ad, input logic [3:0] be, input logic p,
                        input logic oe, input logic ap, input logic ir, input logic tr,
                        input logic pe, input logic se);
        bit was_a, was_d, bp;
        @(negedge clk);
        ad_i = ad; cbe_i = be; par_i = p; ad_oe_i = oe; addr_phase_i = ap;
        irdy_i = ir; trdy_i = tr; perr_en_i = pe; serr_en_i = se;
        @(posedge clk);
        bp = ^{ad, be};
        was_a = pend_addr; was_d = pend_data;
        m_serr = pend_addr && (p ^ pend_par) && se;
        m_perr = pend_data && (p ^ pend_par) && pe;
        pend_addr = !oe && ap;
        pend_data = !oe && !ap && ir && tr;
        pend_par = bp;
        m_oe = oe;
        if (oe) m_par = bp;
        #1;
        chk(oe ? "R1" : "R3", par_o, m_par);
        chk("R2", par_oe_o, m_oe);
        chk(was_d ? (pe ? "R5/R9" : "R6") : "R7", perr_o, m_perr);
        chk(was_a ? (se ? "R4/R9" : "R6") : "R7", serr_o, m_serr);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ad_i = '0; cbe_i = '0; par_i = 0; ad_oe_i = 0; addr_phase_i = 0;
        irdy_i = 0; trdy_i = 0; perr_en_i = 0; serr_en_i = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8", par_o, 1'b0);
        chk("R8", par_oe_o, 1'b0);
        chk("R8", perr_o, 1'b0);
        chk("R8", serr_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // single-bit sweep on received address then data phases (R4, R5)
        for (int b = 0; b < 36; b++) begin
            logic [35:0] v = 36'd1 << b;
            step(v[35:4], v[3:0], 1'b0, 0, 1, 0, 0, 1, 1);
            step(v[35:4], v[3:0], 1'b0, 0, 0, 1, 1, 1, 1);
            step(32'h0, 4'h0, 1'b0, 0, 0, 0, 0, 1, 1);
            step(32'h0, 4'h0, 1'b1, 0, 0, 0, 0, 1, 1);
        end
        // single-bit sweep on driven path, with hold cycles (R1, R3)
        for (int b = 0; b < 36; b++) begin
            logic [35:0] v = 36'd1 << b;
            step(v[35:4], v[3:0], 1'b1, 1, b[0], 1, 1, 1, 1);
            step(~v[35:4], ~v[3:0], 1'b1, 0, 0, 0, 0, 1, 1);
            step(32'hFFFF_FFFF, 4'h0, 1'b0, 0, 0, 1, 0, 1, 1);
        end
        // pseudo-random traffic
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] a, c;
            rs = nxt(rs); a = rs;
            rs = nxt(rs); c = rs;
            step(a, c[3:0], c[4], c[5] & c[6], c[7] & c[8], c[9] | c[10],
                 c[11] | c[12], c[13] | c[14], c[15] | c[16]);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule